// File: doc/BRIEF.md
# Burst Memory Write Engine

This engine drains pixel words from a first-word-fall-through staging FIFO into an external memory controller, one fixed-length burst at a time. The input FIFO shows its head word and an empty flag, and the engine pops it. On the memory side the engine fills the controller's write-data FIFO, which reports its fill level. Once the write-data FIFO holds the complete burst, the engine offers a single write command with the burst's word address on a valid/ready command port. It then waits for the controller's one-cycle write-complete pulse before it stages the next burst.

The engine works only after memory calibration has finished, and only while the write-enable level is high. Each rising edge of write-enable starts a new frame, and the next burst goes to the frame base address. When write-enable drops in the middle of a burst, the engine tops up the remaining slots with zero words and commits the burst, so the controller's write-data FIFO is never left partly filled. Words that arrive while a burst is in flight wait in the staging FIFO and are not lost.

Top module: `burst_wr_engine`

## Requirements
- R1: While calibration-done is low, the engine pops no input word, pushes no memory word and raises no command.
- R2: A word is popped only when write-enable is high and the input FIFO is not empty. Every popped word is pushed into the write-data FIFO unchanged, in pop order, on the following clock cycle.
- R3: Each burst puts exactly BURST_LEN (64) words into the write-data FIFO. No word is pushed while that FIFO already holds BURST_LEN words.
- R4: The write command is raised only when the write-data FIFO reports a count of exactly BURST_LEN.
- R5: When the command is not accepted (command ready low), command valid stays high and the command address stays unchanged until it is accepted.
- R6: From the cycle the command is accepted until the write-complete pulse, nothing is popped or pushed.
- R7: The first burst after a rising edge of write-enable uses address FRAME_BASE (word address, default 0x1000). Each following burst is BURST_LEN higher. If the rising edge comes while a burst is still open, that burst keeps its own address and the reset to FRAME_BASE applies to the next burst.
- R8: When write-enable falls with 1 to BURST_LEN-1 words staged, the engine pushes zero-valued words up to BURST_LEN and then commits the burst. The data FIFO is empty once the write completes.
- R9: When write-enable falls with no word staged, no command is issued and the engine returns to idle.
- R10: After reset, input pop, memory push and command valid are low and the command address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| calib_done | input | 1 | Memory calibration finished |
| wr_en | input | 1 | Frame write enable level; a rising edge starts a frame |
| in_data | input | DATA_W | Head word of the input staging FIFO |
| in_empty | input | 1 | Input staging FIFO is empty |
| in_pop | output | 1 | Pop the input staging FIFO |
| mem_wdata | output | DATA_W | Word for the memory write-data FIFO |
| mem_wpush | output | 1 | Push mem_wdata into the write-data FIFO |
| mem_wcount | input | CNT_W | Fill level of the write-data FIFO |
| cmd_valid | output | 1 | Write command offered |
| cmd_addr | output | ADDR_W | Word address of the burst |
| cmd_ready | input | 1 | Command FIFO accepts the command |
| wr_done | input | 1 | One-cycle pulse: burst write complete |

## Verification
The bench feeds data both in a continuous stream and in a trickle, so a design that miscounts the burst would commit early or overfill the write-data FIFO. It also holds command ready low for many cycles; a design that drops or alters the command under backpressure would lose the burst or write it to the wrong address. It drops write-enable twice, once with a partial burst staged and once with the FIFO empty. A design without padding would leave words stranded, and one that commits an empty burst would write garbage. Finally it raises write-enable again while a padded burst is still open. A design that rebased the address at once would send that burst to the frame base, and one that never rebased would put the next frame after the old one.

// File: rtl/bwe_pkg.sv
package bwe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_PAD,
    ST_CHECK,
    ST_CMD,
    ST_WAIT
  } bwe_state_e;
endpackage

// File: rtl/bwe_stager.sv
// Moves words from the staging FIFO (or zero padding) into the memory
// write-data FIFO and counts the slots of the current burst.
module bwe_stager #(
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 64,
  parameter int CNT_W     = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en,
  input  logic              pad_en,
  input  logic              clear,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_empty,
  output logic              in_pop,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wpush,
  input  logic [CNT_W-1:0]  mem_wcount,
  output logic [CNT_W-1:0]  staged,
  output logic              full
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN);

  logic pad_push;

  assign full     = (staged == LAST);
  assign in_pop   = fill_en && !in_empty && !full;
  assign pad_push = pad_en && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged    <= '0;
      mem_wpush <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_wpush <= in_pop || pad_push;
      mem_wdata <= in_pop ? in_data : '0;
      if (clear)
        staged <= '0;
      else if (in_pop || pad_push)
        staged <= staged + 1'b1;
    end
  end

  AST_NO_OVERSTAGE: assert property (@(posedge clk) disable iff (rst)
    mem_wpush |-> (mem_wcount < LAST)); // R3
endmodule

// File: rtl/bwe_addr_gen.sv
// Burst address generator: rebases on a frame start, steps per completed burst.
module bwe_addr_gen #(
  parameter int          ADDR_W     = 28,
  parameter int          BURST_LEN  = 64,
  parameter int unsigned FRAME_BASE = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              busy,
  input  logic              burst_done,
  output logic [ADDR_W-1:0] next_addr
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(FRAME_BASE);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(BURST_LEN);

  logic rebase_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_addr   <= BASE_A;
      rebase_pend <= 1'b0;
    end else if (burst_done) begin
      next_addr   <= (rebase_pend || frame_start) ? BASE_A : next_addr + STEP_A;
      rebase_pend <= 1'b0;
    end else if (frame_start) begin
      if (busy)
        rebase_pend <= 1'b1;
      else
        next_addr <= BASE_A;
    end
  end
endmodule

// File: rtl/bwe_ctrl.sv
// Burst sequencer: fill, pad, wait for full data FIFO, command, wait for completion.
module bwe_ctrl
  import bwe_pkg::*;
#(
  parameter int ADDR_W    = 28,
  parameter int BURST_LEN = 64,
  parameter int CNT_W     = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              calib_done,
  input  logic              wr_en,
  input  logic              full,
  input  logic [CNT_W-1:0]  staged,
  input  logic [CNT_W-1:0]  mem_wcount,
  input  logic              cmd_ready,
  input  logic              wr_done,
  input  logic [ADDR_W-1:0] next_addr,
  output logic              fill_en,
  output logic              pad_en,
  output logic              clear,
  output logic              busy,
  output logic              burst_done,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output bwe_state_e        state
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN);

  assign fill_en    = (state == ST_FILL) && wr_en;
  assign pad_en     = (state == ST_PAD);
  assign clear      = cmd_valid && cmd_ready;
  assign burst_done = (state == ST_WAIT) && wr_done;
  assign busy       = !((state == ST_IDLE) || ((state == ST_FILL) && (staged == '0)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (calib_done && wr_en) state <= ST_FILL;
        ST_FILL: begin
          if (full)
            state <= ST_CHECK;
          else if (!wr_en)
            state <= (staged == '0) ? ST_IDLE : ST_PAD;
        end
        ST_PAD: if (full) state <= ST_CHECK;
        ST_CHECK: begin
          if (mem_wcount == LAST) begin
            cmd_valid <= 1'b1;
            cmd_addr  <= next_addr;
            state     <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (wr_done)
            state <= (calib_done && wr_en) ? ST_FILL : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr))); // R5
  AST_CMD_STAGED: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (mem_wcount == LAST)); // R4
endmodule

// File: rtl/burst_wr_engine.sv
module burst_wr_engine
  import bwe_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 28,
  parameter int          BURST_LEN  = 64,
  parameter int unsigned FRAME_BASE = 32'h0000_1000,
  localparam int         CNT_W      = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              calib_done,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_empty,
  output logic              in_pop,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wpush,
  input  logic [CNT_W-1:0]  mem_wcount,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_ready,
  input  logic              wr_done
);
  logic              wr_en_q;
  logic              frame_start;
  logic              fill_en, pad_en, clear, busy, burst_done, full;
  logic [CNT_W-1:0]  staged;
  logic [ADDR_W-1:0] next_addr;
  bwe_state_e        state;

  always_ff @(posedge clk) begin
    if (rst) wr_en_q <= 1'b0;
    else     wr_en_q <= wr_en;
  end
  assign frame_start = wr_en && !wr_en_q;

  bwe_ctrl #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .calib_done(calib_done), .wr_en(wr_en),
    .full(full), .staged(staged), .mem_wcount(mem_wcount),
    .cmd_ready(cmd_ready), .wr_done(wr_done), .next_addr(next_addr),
    .fill_en(fill_en), .pad_en(pad_en), .clear(clear), .busy(busy),
    .burst_done(burst_done), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .state(state)
  );

  bwe_stager #(.DATA_W(DATA_W), .BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) u_stager (
    .clk(clk), .rst(rst), .fill_en(fill_en), .pad_en(pad_en), .clear(clear),
    .in_data(in_data), .in_empty(in_empty), .in_pop(in_pop),
    .mem_wdata(mem_wdata), .mem_wpush(mem_wpush), .mem_wcount(mem_wcount),
    .staged(staged), .full(full)
  );

  bwe_addr_gen #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .FRAME_BASE(FRAME_BASE)) u_addr (
    .clk(clk), .rst(rst), .frame_start(frame_start), .busy(busy),
    .burst_done(burst_done), .next_addr(next_addr)
  );

  AST_CALIB_GATE: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && !calib_done) |-> !in_pop); // R1
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> (!in_pop && !mem_wpush)); // R6
endmodule

// File: tb/burst_wr_engine_bench.sv
module burst_wr_engine_bench;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 28;
  localparam int BL     = 64;
  localparam int CNT_W  = $clog2(BL + 1);
  localparam int BASE   = 32'h1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic calib_done = 1'b0;
  logic wr_en = 1'b0;
  logic cmd_ready = 1'b1;
  logic wr_done = 1'b0;
  logic [DATA_W-1:0] in_data;
  logic in_empty, in_pop, mem_wpush, cmd_valid;
  logic [DATA_W-1:0] mem_wdata;
  logic [CNT_W-1:0] mcount = '0;
  logic [ADDR_W-1:0] cmd_addr;

  always #2.5 clk = ~clk;

  // input staging FIFO model
  logic [DATA_W-1:0] src [0:1023];
  int wr_idx = 0;
  int rd_idx = 0;
  assign in_empty = (rd_idx == wr_idx);
  assign in_data  = src[rd_idx[9:0]];

  // memory model state
  logic [DATA_W-1:0] img [0:1023];
  logic [ADDR_W-1:0] baddr [0:15];
  int nb = 0;
  int tmr = 0;
  bit inflight = 1'b0;
  int quiet_viol = 0;
  int over_viol = 0;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  burst_wr_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BURST_LEN(BL), .FRAME_BASE(BASE)) u_burst_wr_engine (
    .clk(clk), .rst(rst), .calib_done(calib_done), .wr_en(wr_en),
    .in_data(in_data), .in_empty(in_empty), .in_pop(in_pop),
    .mem_wdata(mem_wdata), .mem_wpush(mem_wpush), .mem_wcount(mcount),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_ready(cmd_ready),
    .wr_done(wr_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (in_pop) rd_idx <= rd_idx + 1;
    wr_done <= 1'b0;
    if (mem_wpush) begin
      if (mcount >= CNT_W'(BL)) over_viol++;
      img[(nb * BL + int'(mcount)) % 1024] <= mem_wdata;
      mcount <= mcount + 1'b1;
    end
    if (inflight && (in_pop || mem_wpush)) quiet_viol++;
    if (cmd_valid && cmd_ready) begin
      chk(mcount == CNT_W'(BL), "R4 count at command", 32'(mcount), BL);
      baddr[nb % 16] <= cmd_addr;
      nb <= nb + 1;
      tmr <= 8;
      inflight <= 1'b1;
    end else if (tmr != 0) begin
      tmr <= tmr - 1;
      if (tmr == 1) begin
        wr_done <= 1'b1;
        mcount <= '0;
        inflight <= 1'b0;
      end
    end
  end

  task automatic push_words(input int n, input logic [31:0] base, input int gap);
    for (int i = 0; i < n; i++) begin
      src[wr_idx % 1024] = base + 32'(i);
      wr_idx = wr_idx + 1;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic wait_bursts(input int target, input string tag);
    int t = 0;
    while (!(nb >= target && !inflight && tmr == 0) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(nb >= target, tag, nb, target);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_burst(input int idx, input logic [31:0] addr, input logic [31:0] base, input int nreal, input string tag);
    chk(baddr[idx] == addr, tag, 32'(baddr[idx]), addr);
    for (int j = 0; j < BL; j++) begin
      logic [31:0] e;
      e = (j < nreal) ? base + 32'(j) : 32'h0;
      if (img[idx * BL + j] != e) begin
        chk(1'b0, tag, img[idx * BL + j], e);
        break;
      end
    end
    n_chk++;
  endtask

  task automatic t_reset();
    chk(in_pop == 1'b0, "R10 pop", 32'(in_pop), 0);
    chk(mem_wpush == 1'b0, "R10 push", 32'(mem_wpush), 0);
    chk(cmd_valid == 1'b0 && cmd_addr == '0, "R10 cmd", 32'(cmd_addr), 0);
  endtask

  task automatic t_no_calib();
    wr_en = 1'b1;
    push_words(64, 32'hA000, 0);
    repeat (30) @(negedge clk);
    chk(rd_idx == 0, "R1 no pop before calib", rd_idx, 0);
    chk(nb == 0 && !cmd_valid && mcount == 0, "R1 no write before calib", nb, 0);
  endtask

  task automatic t_two_bursts();
    calib_done = 1'b1;
    push_words(64, 32'hA040, 0);
    wait_bursts(2, "R3 two bursts");
    chk_burst(0, BASE, 32'hA000, BL, "R7 R2 burst0");
    chk_burst(1, BASE + BL, 32'hA040, BL, "R7 R2 burst1");
    repeat (20) @(negedge clk);
    chk(nb == 2 && mcount == 0, "R3 no extra burst", nb, 2);
  endtask

  task automatic t_trickle();
    push_words(64, 32'hB000, 3);
    wait_bursts(3, "R2 trickle burst");
    chk_burst(2, BASE + 2 * BL, 32'hB000, BL, "R2 trickle data");
  endtask

  task automatic t_backpressure();
    int t = 0;
    cmd_ready = 1'b0;
    push_words(64, 32'hC000, 0);
    while (!cmd_valid && t < 500) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
    chk(cmd_valid == 1'b1, "R5 valid held", 32'(cmd_valid), 1);
    chk(cmd_addr == ADDR_W'(BASE + 3 * BL), "R5 addr held", 32'(cmd_addr), BASE + 3 * BL);
    chk(nb == 3, "R5 not accepted", nb, 3);
    cmd_ready = 1'b1;
    wait_bursts(4, "R5 accepted");
    chk_burst(3, BASE + 3 * BL, 32'hC000, BL, "R5 data");
    chk(quiet_viol == 0, "R6 quiet while in flight", quiet_viol, 0);
  endtask

  task automatic t_pad();
    push_words(10, 32'hD000, 0);
    repeat (20) @(negedge clk);
    chk(nb == 4 && !cmd_valid, "R8 partial not committed", nb, 4);
    wr_en = 1'b0;
    wait_bursts(5, "R8 padded burst");
    chk_burst(4, BASE + 4 * BL, 32'hD000, 10, "R8 pad data");
    chk(mcount == 0, "R8 data fifo empty", 32'(mcount), 0);
  endtask

  task automatic t_idle_drop();
    wr_en = 1'b1;
    repeat (5) @(negedge clk);
    wr_en = 1'b0;
    repeat (30) @(negedge clk);
    chk(nb == 5 && !cmd_valid && mcount == 0, "R9 no empty burst", nb, 5);
  endtask

  task automatic t_rise();
    wr_en = 1'b1;
    push_words(64, 32'hE000, 0);
    wait_bursts(6, "R7 frame restart");
    chk_burst(5, BASE, 32'hE000, BL, "R7 rebase");
  endtask

  task automatic t_rise_busy();
    push_words(5, 32'hF000, 0);
    repeat (10) @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b1;
    wait_bursts(7, "R8 pad on blip");
    chk_burst(6, BASE + BL, 32'hF000, 5, "R7 open burst keeps address");
    push_words(64, 32'hF100, 0);
    wait_bursts(8, "R7 pending rebase");
    chk_burst(7, BASE, 32'hF100, BL, "R7 rebase after open burst");
    chk(over_viol == 0, "R3 no overfill", over_viol, 0);
    chk(quiet_viol == 0, "R6 quiet while in flight", quiet_viol, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_no_calib();
    t_two_bursts();
    t_trickle();
    t_backpressure();
    t_pad();
    t_idle_drop();
    t_rise();
    t_rise_busy();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule